// File: doc/BRIEF.md
# Two-Stage Watchdog Timer Register Block

This block is a watchdog timer that sits behind a 16-byte register window on a simple synchronous byte port. Software loads a 6-bit timeout counted in slow ticks (one tick lasts 0.6 s in the target system, so N seconds is written as N*10/6). It then clears a halt bit to start the countdown and keeps the system alive by writing a reload code. The slow tick comes from a free-running prescaler that divides the system clock by the parameter `TICK_DIV`.

When the counter is found at zero on a tick for the first time, the block flags a first timeout and can raise a one-cycle management-interrupt request. It then reloads and counts again. If a second expiry follows with no software reload in between, and reboot is enabled, the block records a sticky second-timeout flag and holds a system-reset request until a reset arrives. The second-timeout flag survives the warm (system) reset that the request normally causes. Only a power-on reset or software clears it.

Register window: 0x0 reload (write) and current counter (read). 0x1 timer register: bits [5:0] timeout, bits [7:6] spare storage. 0x4 status: bit0 first timeout, bit1 second timeout. 0x8 is the low byte of a 32-bit control word, with bit0 halt. 0xC config: bit0 interrupt enable, bit1 reboot enable.

Top module: `wdt_top`

## Requirements
- R1: After power-on reset the timer register reads `DEF_TIMEOUT` with bits [7:6] zero, the counter reads `DEF_TIMEOUT`, halt (0x8 bit0) is 1, config 0xC reads 0x01 (interrupt enabled, reboot disabled), status reads 0, and both request outputs are low.
- R2: A write to 0x1 whose bits [5:0] are 4 or more reads back exactly as written, and bits [5:0] become the reload value.
- R3: A write to 0x1 whose bits [5:0] are 0 to 3 keeps the previous bits [5:0]. Bits [7:6] still take the written value.
- R4: Writing exactly 0x01 to 0x0 loads the counter from bits [5:0] of the timer register on the next clock and returns the block to the first stage. The reload wins over a tick in the same cycle. Any other value written to 0x0 has no effect.
- R5: A tick occurs every `TICK_DIV` clocks after reset, whatever the state of halt. On a tick with halt clear, a non-zero counter decrements by one. With halt set, the counter holds and nothing expires.
- R6: On a tick with halt clear, counter zero and the block in its first stage, the counter reloads and status bit0 sets. If config bit0 is set, `smiReq` is high for exactly the next cycle.
- R7: A later expiry in the second stage with config bit1 set sets status bit1 and raises `sysResetReq`, which stays high until a reset. With config bit1 clear, a second-stage expiry only reloads the counter.
- R8: Status bits are write-one-to-clear at 0x4. A bit written 0 is unchanged, and a set event in the same cycle beats the clear.
- R9: Holding `sysRst_n` low restores every register to its R1 value except status bit1, which keeps its value. `rstPor_n` clears status bit1 as well.
- R10: The counter reads at 0x0 as {2'b00, count}. Addresses other than 0x0, 0x1, 0x4, 0x8 and 0xC read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstPor_n | input | 1 | Asynchronous active-low power-on reset |
| sysRst_n | input | 1 | Asynchronous active-low warm reset, keeps the second-timeout flag |
| addr | input | 4 | Byte address within the register window |
| wrEn | input | 1 | Write strobe for one clock |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| smiReq | output | 1 | One-cycle management-interrupt request on the first expiry |
| sysResetReq | output | 1 | System-reset request, held until reset |

## Verification
The assertions assume that the two resets are only released between clock edges and that `DEF_TIMEOUT` is at least the minimum timeout of 4. Under that assumption a reload always loads at least 4, so two expiries can never fall on adjacent cycles. The bench drives every input at the falling edge and releases the resets away from the rising edge. It writes timeouts below 4 only to check that they are ignored. It runs a short `TICK_DIV` of 4, so both expiry stages and the reset request are reached in a few dozen clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int TMO_W = 6;

  localparam logic [3:0] A_RELOAD = 4'h0;
  localparam logic [3:0] A_TMR    = 4'h1;
  localparam logic [3:0] A_STS    = 4'h4;
  localparam logic [3:0] A_CTL    = 4'h8;
  localparam logic [3:0] A_CFG    = 4'hC;

  // control -> datapath
  typedef struct packed {
    logic             reload;
    logic             halt;
    logic [TMO_W-1:0] timeout;
  } wdtStrb_t;

  // datapath -> control
  typedef struct packed {
    logic expire1;
    logic expire2;
  } wdtEvt_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count
  import wdt_pkg::*;
#(
  parameter int TICK_DIV    = 60_000_000,
  parameter int DEF_TIMEOUT = 50
) (
  input  logic             clk,
  input  logic             warmRst_n,
  input  wdtStrb_t         strb,
  output wdtEvt_t          evt,
  output logic [TMO_W-1:0] cnt
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre;
  logic             stage;
  logic             tick, run, zero;

  assign tick = (pre == PRE_LAST);
  assign run  = tick && !strb.halt && !strb.reload;
  assign zero = (cnt == '0);

  assign evt.expire1 = run && zero && !stage;
  assign evt.expire2 = run && zero && stage;

  always_ff @(posedge clk or negedge warmRst_n) begin
    if (!warmRst_n) begin
      pre   <= '0;
      cnt   <= TMO_W'(DEF_TIMEOUT);
      stage <= 1'b0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (strb.reload) begin
        cnt   <= strb.timeout;
        stage <= 1'b0;
      end else if (run) begin
        if (zero) begin
          cnt   <= strb.timeout;
          stage <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DEF_TIMEOUT = 50,
  parameter int MIN_TIMEOUT = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstPor_n,
  input  logic              sysRst_n,
  input  logic              warmRst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  wdtEvt_t           evt,
  input  logic [TMO_W-1:0]  cnt,
  output wdtStrb_t          strb,
  output logic [DATA_W-1:0] rdData,
  output logic              smiReq,
  output logic              sysResetReq
);
  logic [DATA_W-1:0] tmrReg;
  logic halt, smiEn, rebootEn, firstTo, secondTo;
  logic selTmr, selSts, selCtl, selCfg, tmoOk, fire2;

  assign selTmr = wrEn && (addr == ADDR_W'(A_TMR));
  assign selSts = wrEn && (addr == ADDR_W'(A_STS));
  assign selCtl = wrEn && (addr == ADDR_W'(A_CTL));
  assign selCfg = wrEn && (addr == ADDR_W'(A_CFG));
  assign tmoOk  = (wrData[TMO_W-1:0] >= TMO_W'(MIN_TIMEOUT));
  assign fire2  = evt.expire2 && rebootEn;

  assign strb.reload  = wrEn && (addr == ADDR_W'(A_RELOAD)) && (wrData == DATA_W'(1));
  assign strb.halt    = halt;
  assign strb.timeout = tmrReg[TMO_W-1:0];

  always_ff @(posedge clk or negedge warmRst_n) begin
    if (!warmRst_n) begin
      tmrReg      <= DATA_W'(DEF_TIMEOUT);
      halt        <= 1'b1;
      smiEn       <= 1'b1;
      rebootEn    <= 1'b0;
      firstTo     <= 1'b0;
      smiReq      <= 1'b0;
      sysResetReq <= 1'b0;
    end else begin
      if (selTmr)
        tmrReg <= tmoOk ? wrData : {wrData[DATA_W-1:TMO_W], tmrReg[TMO_W-1:0]};
      if (selCtl) halt <= wrData[0];
      if (selCfg) begin
        smiEn    <= wrData[0];
        rebootEn <= wrData[1];
      end
      if (evt.expire1) firstTo <= 1'b1;
      else if (selSts && wrData[0]) firstTo <= 1'b0;
      smiReq <= evt.expire1 && smiEn;
      if (fire2) sysResetReq <= 1'b1;
    end
  end

  // second-timeout flag lives on the power-on reset only
  always_ff @(posedge clk or negedge rstPor_n) begin
    if (!rstPor_n) secondTo <= 1'b0;
    else if (sysRst_n) begin
      if (fire2) secondTo <= 1'b1;
      else if (selSts && wrData[1]) secondTo <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(A_RELOAD): rdData = DATA_W'(cnt);
      ADDR_W'(A_TMR):    rdData = tmrReg;
      ADDR_W'(A_STS):    rdData = DATA_W'({secondTo, firstTo});
      ADDR_W'(A_CTL):    rdData = DATA_W'(halt);
      ADDR_W'(A_CFG):    rdData = DATA_W'({rebootEn, smiEn});
      default:           rdData = '0;
    endcase
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TICK_DIV    = 60_000_000,
  parameter int DEF_TIMEOUT = 50,
  parameter int MIN_TIMEOUT = 4
) (
  input  logic       clk,
  input  logic       rstPor_n,
  input  logic       sysRst_n,
  input  logic [3:0] addr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       smiReq,
  output logic       sysResetReq
);
  wdtStrb_t         strb;
  wdtEvt_t          evt;
  logic [TMO_W-1:0] cnt;
  logic             warmRst_n;

  assign warmRst_n = rstPor_n & sysRst_n;

  wdt_regs #(
    .DEF_TIMEOUT(DEF_TIMEOUT), .MIN_TIMEOUT(MIN_TIMEOUT), .ADDR_W(4), .DATA_W(8)
  ) uRegs (
    .clk(clk), .rstPor_n(rstPor_n), .sysRst_n(sysRst_n), .warmRst_n(warmRst_n),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .evt(evt), .cnt(cnt),
    .strb(strb), .rdData(rdData), .smiReq(smiReq), .sysResetReq(sysResetReq)
  );

  wdt_count #(.TICK_DIV(TICK_DIV), .DEF_TIMEOUT(DEF_TIMEOUT)) uCount (
    .clk(clk), .warmRst_n(warmRst_n), .strb(strb), .evt(evt), .cnt(cnt)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk
  import wdt_pkg::*;
#(
  parameter int MIN_TIMEOUT = 4
) (
  input logic             clk,
  input logic             rstPor_n,
  input logic             sysRst_n,
  input logic             smiReq,
  input logic             sysResetReq,
  input wdtStrb_t         strb,
  input wdtEvt_t          evt,
  input logic [TMO_W-1:0] cnt
);
  // R3
  tmo_floor_chk: assert property (@(posedge clk) disable iff (!rstPor_n || !sysRst_n)
    strb.timeout >= TMO_W'(MIN_TIMEOUT));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstPor_n || !sysRst_n)
    (strb.halt && !strb.reload) |=> $stable(cnt));

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rstPor_n || !sysRst_n)
    (!strb.reload && !evt.expire1 && !evt.expire2) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  // R6
  smi_cause_chk: assert property (@(posedge clk) disable iff (!rstPor_n || !sysRst_n)
    smiReq |-> $past(evt.expire1));

  // R6
  smi_pulse_chk: assert property (@(posedge clk) disable iff (!rstPor_n || !sysRst_n)
    smiReq |=> !smiReq);

  // R7
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rstPor_n || !sysRst_n)
    $rose(sysResetReq) |-> $past(evt.expire2));

  // R7
  rst_hold_chk: assert property (@(posedge clk) disable iff (!rstPor_n || !sysRst_n)
    sysResetReq |=> sysResetReq);
endmodule

bind wdt_top wdt_chk #(.MIN_TIMEOUT(MIN_TIMEOUT)) uChk (
  .clk(clk), .rstPor_n(rstPor_n), .sysRst_n(sysRst_n), .smiReq(smiReq),
  .sysResetReq(sysResetReq), .strb(strb), .evt(evt), .cnt(cnt)
);

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;
  localparam int DIV = 4;
  localparam int DEF = 50;
  localparam int LIMIT = 200000;

  logic clk = 1'b0, rstPor_n = 1'b0, sysRst_n = 1'b1;
  logic [3:0] addr = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic smiReq, sysResetReq;

  int nCmp = 0, nBad = 0, cyc = 0;
  bit done = 0;

  wdt_top #(.TICK_DIV(DIV), .DEF_TIMEOUT(DEF)) dut (
    .clk(clk), .rstPor_n(rstPor_n), .sysRst_n(sysRst_n), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .smiReq(smiReq), .sysResetReq(sysResetReq));

  always #5 clk = ~clk;

  // behavioural reference
  int mCnt, mStage, mPre, mTmr, mHalt, mSmiEn, mReb, mFirst, mSecond, mRst, mSmi;

  task automatic mWarm();
    mCnt = DEF; mStage = 0; mPre = 0; mTmr = DEF; mHalt = 1; mSmiEn = 1; mReb = 0;
    mFirst = 0; mRst = 0; mSmi = 0;
  endtask

  always @(posedge clk) begin
    if (!rstPor_n) begin mWarm(); mSecond = 0; end
    else if (!sysRst_n) mWarm();
    else begin
      bit tk, e1, e2;
      int d;
      d = int'(wrData);
      tk = (mPre == DIV - 1);
      mPre = tk ? 0 : mPre + 1;
      e1 = 0; e2 = 0;
      if (wrEn && addr == 4'h0 && d == 1) begin mCnt = mTmr % 64; mStage = 0; end
      else if (tk && !mHalt) begin
        if (mCnt == 0) begin
          mCnt = mTmr % 64;
          if (mStage == 0) begin e1 = 1; mStage = 1; end else e2 = 1;
        end else mCnt = mCnt - 1;
      end
      mSmi = int'(e1 && mSmiEn != 0);
      if (wrEn && addr == 4'h4) begin
        if (d % 2 == 1) mFirst = 0;
        if ((d / 2) % 2 == 1) mSecond = 0;
      end
      if (e1) mFirst = 1;
      if (e2 && mReb != 0) begin mSecond = 1; mRst = 1; end
      if (wrEn && addr == 4'h1) mTmr = (d % 64 >= 4) ? d : ((d / 64) * 64 + mTmr % 64);
      if (wrEn && addr == 4'h8) mHalt = d % 2;
      if (wrEn && addr == 4'hC) begin mSmiEn = d % 2; mReb = (d / 2) % 2; end
    end
  end

  function automatic int mRead(input logic [3:0] a);
    case (a)
      4'h0: return mCnt;
      4'h1: return mTmr;
      4'h4: return mSecond * 2 + mFirst;
      4'h8: return mHalt;
      4'hC: return mReb * 2 + mSmiEn;
      default: return 0;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] a);
    case (a)
      4'h0: return "R5";
      4'h1: return "R2";
      4'h4: return "R8";
      4'h8: return "R5";
      4'hC: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #2;
    if (rstPor_n && sysRst_n && !done) begin
      chk(int'(rdData) == mRead(addr), reqOf(addr), int'(rdData), mRead(addr));
      chk(int'(smiReq) == mSmi, "R6", int'(smiReq), mSmi);
      chk(int'(sysResetReq) == mRst, "R7", int'(sysResetReq), mRst);
    end
  end

  task automatic finishUp();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired, actual=%0d expected<%0d cycles", cyc, LIMIT);
      finishUp();
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0; addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    addr = a; #1; v = int'(rdData);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); addr = 4'h0; end
  endtask

  task automatic waitFor(input bit useRst, input int maxCyc, output bit seen);
    seen = 0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk); #1;
      if (useRst ? sysResetReq : smiReq) begin seen = 1; break; end
    end
  endtask

  initial begin
    int v, v0, smiCnt;
    bit seen;
    repeat (3) @(negedge clk);
    rstPor_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h1, v); chk(v == DEF, "R1", v, DEF);
    rd(4'h0, v); chk(v == DEF, "R1", v, DEF);
    rd(4'h8, v); chk(v == 1, "R1", v, 1);
    rd(4'hC, v); chk(v == 1, "R1", v, 1);
    rd(4'h4, v); chk(v == 0, "R1", v, 0);
    chk(smiReq == 0 && sysResetReq == 0, "R1", int'({smiReq, sysResetReq}), 0);
    // R2 valid timeout with spare bits
    wr(4'h1, 8'hC5); rd(4'h1, v); chk(v == 8'hC5, "R2", v, 8'hC5);
    // R3 small timeouts ignored in low field
    wr(4'h1, 8'h02); rd(4'h1, v); chk(v == 8'h05, "R3", v, 8'h05);
    wr(4'h1, 8'h43); rd(4'h1, v); chk(v == 8'h45, "R3", v, 8'h45);
    wr(4'h1, 8'h06); rd(4'h1, v); chk(v == 8'h06, "R2", v, 8'h06);
    // R4 reload while halted
    wr(4'h0, 8'h01); rd(4'h0, v); chk(v == 6, "R4", v, 6);
    idle(20); rd(4'h0, v); chk(v == 6, "R5", v, 6);
    // R10 unmapped reads
    rd(4'h3, v); chk(v == 0, "R10", v, 0);
    rd(4'hF, v); chk(v == 0, "R10", v, 0);
    // R6 first expiry with interrupt
    wr(4'h8, 8'h00);
    waitFor(1'b0, 100, seen); chk(seen, "R6", int'(seen), 1);
    rd(4'h4, v); chk(v == 1, "R6", v, 1);
    // R7 second expiry with reboot disabled
    idle(40);
    chk(sysResetReq == 0, "R7", int'(sysResetReq), 0);
    rd(4'h4, v); chk(v == 1, "R7", v, 1);
    // R8 write-one-to-clear
    wr(4'h4, 8'h00); rd(4'h4, v); chk(v == 1, "R8", v, 1);
    wr(4'h4, 8'h01); rd(4'h4, v); chk(v == 0, "R8", v, 0);
    // R4 other reload values ignored
    wr(4'h8, 8'h01); rd(4'h0, v0);
    wr(4'h0, 8'h02); rd(4'h0, v); chk(v == v0, "R4", v, v0);
    idle(20); rd(4'h0, v); chk(v == v0, "R5", v, v0);
    // R7 reboot path
    wr(4'hC, 8'h03); wr(4'h0, 8'h01); wr(4'h8, 8'h00);
    waitFor(1'b1, 200, seen); chk(seen, "R7", int'(seen), 1);
    rd(4'h4, v); chk(v == 3, "R7", v, 3);
    idle(10); chk(sysResetReq == 1, "R7", int'(sysResetReq), 1);
    // R9 warm reset keeps second flag
    @(negedge clk); sysRst_n = 1'b0;
    repeat (3) @(negedge clk);
    sysRst_n = 1'b1;
    rd(4'h4, v); chk(v == 2, "R9", v, 2);
    rd(4'h1, v); chk(v == DEF, "R9", v, DEF);
    rd(4'h8, v); chk(v == 1, "R9", v, 1);
    chk(sysResetReq == 0, "R9", int'(sysResetReq), 0);
    // R6 interrupt disabled
    wr(4'hC, 8'h00); wr(4'h1, 8'h04); wr(4'h0, 8'h01); wr(4'h8, 8'h00);
    smiCnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); addr = 4'h0; #1; if (smiReq) smiCnt++;
    end
    chk(smiCnt == 0, "R6", smiCnt, 0);
    rd(4'h4, v); chk(v == 3, "R6", v, 3);
    // R1 power-on reset clears the second flag
    @(negedge clk); rstPor_n = 1'b0;
    repeat (3) @(negedge clk);
    rstPor_n = 1'b1;
    rd(4'h4, v); chk(v == 0, "R1", v, 0);
    idle(2);
    finishUp();
  end
endmodule